// File: doc/BRIEF.md
# System Power State Monitor

This block watches three board-level status lines: a power-good input, an active-low lid-closed input and an active-low host-suspended input. It resolves them by fixed priority into one of four system power states. When the resolved state changes, it emits a one-cycle alert strobe that carries both the previous and the new state code. It also watches a parameterised group of active-low switch inputs that can raise interrupts. The power-good, lid and switch lines raise an event on both rising and falling edges. These events are gathered in a sticky cause mask, which stays set until the controller acknowledges it.

The block also chooses the controller's own activity level. It selects run while an event awaits acknowledgement, while any switch is held low, or while a host transaction is in progress. It selects wait while any timer-driven function is enabled, and stop otherwise. All inputs from the board pass through a two-flop synchronizer before decoding and edge detection. The alert is a plain strobe with no back-pressure: nothing stalls it. Events that occur before the controller acknowledges are not lost, because they accumulate in the mask.

Top module: `pwr_state_monitor`

## Requirements
- R1: State code 3 (critical) is shown whenever synchronized power-good is low, regardless of lid and suspend.
- R2: State code 2 (lid closed) is shown when power-good is high and the lid line is low, regardless of the suspend line.
- R3: State code 1 (host suspended) is shown when power-good and lid are high and the suspend line is low.
- R4: State code 0 (normal) is shown when all three lines are high; this is also the reset state.
- R5: A change on a board input reaches `state_o` on the third rising edge after the change. Each change of state produces exactly one alert strobe, high for one cycle, with `alert_old_o` holding the prior code and `alert_new_o` holding the new code.
- R6: A rising or falling edge on power-good sets mask bit 0, on lid sets bit 1, and on switch i sets bit 2+i. The bit is set on the same edge at which the state would update.
- R7: Mask bits are sticky and accumulate until `ack_i` is high at a rising edge, which clears them. An edge registered on that same clock edge stays set.
- R8: A change on the suspend line alone sets no mask bit. While the lid is closed, it changes neither the state nor the alert.
- R9: `act_mode_o` is 0 (stop) when there is no pending event, no switch held low, no timer enabled and no host transaction.
- R10: `act_mode_o` is 1 (wait) one edge after any `timer_en_i` bit goes high, provided no run demand exists.
- R11: `act_mode_o` is 2 (run) one edge after any run demand appears. Run demand is: an event pending (from its mask or state update until acknowledged), any switch held low, or `host_busy_i` high. Run takes priority over wait.
- R12: An input pulse that the synchronizer captures for a single cycle still registers as an edge in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Power-good line, high when supply is good |
| lid_n_i | input | 1 | Lid-closed line, active low |
| hsusp_n_i | input | 1 | Host-suspended line, active low |
| sw_n_i | input | NSW | Interrupt-capable switch lines, active low |
| timer_en_i | input | NTMR | Timer-dependent functions enabled |
| host_busy_i | input | 1 | Host transaction in progress |
| ack_i | input | 1 | Acknowledge; clears cause mask and pending event |
| state_o | output | 2 | Current system power state code |
| alert_stb_o | output | 1 | One-cycle strobe on state change |
| alert_old_o | output | 2 | State code before the change |
| alert_new_o | output | 2 | State code after the change |
| edge_mask_o | output | NSW+2 | Sticky edge cause mask |
| act_mode_o | output | 2 | Activity mode: 0 stop, 1 wait, 2 run |

## Verification
A wrong decode priority shows up on `state_o` and in the alert code pair three cycles after the offending input pattern. A wrong alert count is caught by the scoreboard: an extra strobe has no queued entry to match, and a missing one leaves an entry behind. A broken sticky mask or acknowledge path shows on `edge_mask_o` within one cycle of the event or the acknowledge. It then shows on `act_mode_o` one cycle later, as a mode that fails to fall back to stop or to hold at run.

// File: rtl/pwr_mon_pkg.sv
package pwr_mon_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_HSUSP  = 2'd1,
    ST_LIDCL  = 2'd2,
    ST_CRIT   = 2'd3
  } sys_state_e;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_RUN  = 2'd2
  } act_mode_e;

  // Priority: power-good, then lid, then host-suspend
  function automatic sys_state_e decode_state(input logic pg, input logic lid_n, input logic hs_n);
    if (!pg)         return ST_CRIT;
    else if (!lid_n) return ST_LIDCL;
    else if (!hs_n)  return ST_HSUSP;
    else             return ST_NORMAL;
  endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1_q, st2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q <= RST_VAL[i];
        st2_q <= RST_VAL[i];
      end else begin
        st1_q <= async_i[i];
        st2_q <= st1_q;
      end
    end
    assign sync_o[i] = st2_q;
  end
endmodule

// File: rtl/pm_edge_tracker.sv
module pm_edge_tracker #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines_i,
  input  logic         chg_i,
  input  logic         ack_i,
  output logic [W-1:0] edge_mask_o,
  output logic         pending_o
);
  logic [W-1:0] prev_q, mask_q, edges_w;
  logic         pend_q;

  assign edges_w = lines_i ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
      mask_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lines_i;
      mask_q <= (ack_i ? '0 : mask_q) | edges_w;
      if ((|edges_w) || chg_i) pend_q <= 1'b1;
      else if (ack_i)          pend_q <= 1'b0;
    end
  end

  assign edge_mask_o = mask_q;
  assign pending_o   = pend_q;

  // R7
  mask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

  // R6
  edge_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edges_w) |=> (pend_q && (mask_q != '0)));

endmodule

// File: rtl/pm_state_decode.sv
module pm_state_decode
  import pwr_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_i,
  input  logic       lid_n_i,
  input  logic       hs_n_i,
  output sys_state_e state_o,
  output logic       chg_o,
  output logic       alert_stb_o,
  output sys_state_e alert_old_o,
  output sys_state_e alert_new_o
);
  sys_state_e state_d, state_q, old_q, new_q;
  logic       stb_q;

  assign state_d = decode_state(pg_i, lid_n_i, hs_n_i);
  assign chg_o   = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      old_q   <= ST_NORMAL;
      new_q   <= ST_NORMAL;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= chg_o;
      if (chg_o) begin
        old_q <= state_q;
        new_q <= state_d;
      end
    end
  end

  assign state_o     = state_q;
  assign alert_stb_o = stb_q;
  assign alert_old_o = old_q;
  assign alert_new_o = new_q;

  // R1
  crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pg_i) |-> (state_q == ST_CRIT));

  // R5
  chg_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> stb_q);

  // R5
  alert_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (old_q == $past(state_q)));

endmodule

// File: rtl/pm_activity.sv
module pm_activity
  import pwr_mon_pkg::*;
#(
  parameter int NTMR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pending_i,
  input  logic            hold_i,
  input  logic [NTMR-1:0] timer_en_i,
  input  logic            host_busy_i,
  output act_mode_e       mode_o
);
  act_mode_e mode_d, mode_q;
  logic run_dem, wait_dem;

  assign run_dem  = pending_i | hold_i | host_busy_i;
  assign wait_dem = |timer_en_i;

  always_comb begin
    if (run_dem)       mode_d = MODE_RUN;
    else if (wait_dem) mode_d = MODE_WAIT;
    else               mode_d = MODE_STOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STOP;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R11
  busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_busy_i || pending_i) |-> (mode_q == MODE_RUN));

  // R10
  timer_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past((|timer_en_i) && !pending_i && !hold_i && !host_busy_i) |-> (mode_q == MODE_WAIT));

  // R9
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(|timer_en_i) && !pending_i && !hold_i && !host_busy_i) |-> (mode_q == MODE_STOP));

endmodule

// File: rtl/pwr_state_monitor.sv
module pwr_state_monitor
  import pwr_mon_pkg::*;
#(
  parameter int NSW  = 2,
  parameter int NTMR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok_i,
  input  logic              lid_n_i,
  input  logic              hsusp_n_i,
  input  logic [NSW-1:0]    sw_n_i,
  input  logic [NTMR-1:0]   timer_en_i,
  input  logic              host_busy_i,
  input  logic              ack_i,
  output logic [1:0]        state_o,
  output logic              alert_stb_o,
  output logic [1:0]        alert_old_o,
  output logic [1:0]        alert_new_o,
  output logic [NSW+1:0]    edge_mask_o,
  output logic [1:0]        act_mode_o
);
  localparam int NLINE = NSW + 2;
  localparam int NSYNC = NSW + 3;

  logic [NSYNC-1:0] sync_w;
  logic             pg_s, lid_s, hs_s;
  logic [NSW-1:0]   sw_s;
  logic             chg_w, pend_w, hold_w;
  sys_state_e       st_w, old_w, new_w;
  act_mode_e        mode_w;

  pm_sync #(.W(NSYNC), .RST_VAL({NSYNC{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sw_n_i, hsusp_n_i, lid_n_i, pwr_ok_i}),
    .sync_o(sync_w)
  );

  assign pg_s   = sync_w[0];
  assign lid_s  = sync_w[1];
  assign hs_s   = sync_w[2];
  assign sw_s   = sync_w[NSYNC-1:3];
  assign hold_w = ~(&sw_s);

  pm_state_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .pg_i(pg_s), .lid_n_i(lid_s), .hs_n_i(hs_s),
    .state_o(st_w), .chg_o(chg_w),
    .alert_stb_o(alert_stb_o), .alert_old_o(old_w), .alert_new_o(new_w)
  );

  pm_edge_tracker #(.W(NLINE), .RST_VAL({NLINE{1'b1}})) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lines_i({sw_s, lid_s, pg_s}),
    .chg_i(chg_w), .ack_i(ack_i),
    .edge_mask_o(edge_mask_o), .pending_o(pend_w)
  );

  pm_activity #(.NTMR(NTMR)) u_act (
    .clk(clk), .rst_n(rst_n),
    .pending_i(pend_w), .hold_i(hold_w),
    .timer_en_i(timer_en_i), .host_busy_i(host_busy_i),
    .mode_o(mode_w)
  );

  assign state_o     = st_w;
  assign alert_old_o = old_w;
  assign alert_new_o = new_w;
  assign act_mode_o  = mode_w;

endmodule

// File: tb/pwr_state_monitor_test.sv
`timescale 1ns/1ps
module pwr_state_monitor_test;
  localparam int NSW = 2, NTMR = 2;

  logic clk = 0, rst_n = 0;
  logic pwr_ok_i = 1, lid_n_i = 1, hsusp_n_i = 1, host_busy_i = 0, ack_i = 0;
  logic [NSW-1:0]  sw_n_i = '1;
  logic [NTMR-1:0] timer_en_i = '0;
  logic [1:0] state_o, alert_old_o, alert_new_o, act_mode_o;
  logic alert_stb_o;
  logic [NSW+1:0] edge_mask_o;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct packed { logic [1:0] o; logic [1:0] n; } alert_t;
  alert_t exp_q[$];
  logic [1:0] mstate = 2'd0;

  always #4 clk = ~clk;

  pwr_state_monitor #(.NSW(NSW), .NTMR(NTMR)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] mdec(input logic pg, input logic lid, input logic hs);
    if (!pg) return 2'd3;
    if (!lid) return 2'd2;
    if (!hs) return 2'd1;
    return 2'd0;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push expected alert when the decoded state moves
  task automatic drive_sys(input logic pg, input logic lid, input logic hs);
    logic [1:0] ns;
    ns = mdec(pg, lid, hs);
    if (ns != mstate) exp_q.push_back('{o: mstate, n: ns});
    mstate = ns;
    pwr_ok_i = pg; lid_n_i = lid; hsusp_n_i = hs;
  endtask

  task automatic do_ack();
    ack_i = 1; tick(1); ack_i = 0;
  endtask

  // monitor: pop and compare on every strobe (R5)
  always @(negedge clk) begin
    if (rst_n && alert_stb_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected alert", {alert_old_o, alert_new_o}, 0);
      end else begin
        alert_t e;
        e = exp_q.pop_front();
        chk(alert_old_o == e.o && alert_new_o == e.n, "R5 alert codes",
            {alert_old_o, alert_new_o}, {e.o, e.n});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R4 R9 reset state
    chk(state_o == 0, "R4 reset state", state_o, 0);
    chk(act_mode_o == 0, "R9 reset mode", act_mode_o, 0);
    chk(edge_mask_o == 0, "R7 reset mask", edge_mask_o, 0);

    // lid closed
    drive_sys(1, 0, 1); tick(3);
    chk(state_o == 2, "R2 lid closed", state_o, 2);
    chk(edge_mask_o == 4'b0010, "R6 lid edge bit", edge_mask_o, 2);
    tick(1);
    chk(act_mode_o == 2, "R11 run while pending", act_mode_o, 2);
    do_ack();
    chk(edge_mask_o == 0, "R7 ack clears", edge_mask_o, 0);
    tick(1);
    chk(act_mode_o == 0, "R9 stop after ack", act_mode_o, 0);

    // suspend while lid closed: no state change, no mask bit
    drive_sys(1, 0, 0); tick(4);
    chk(state_o == 2, "R2 lid over suspend", state_o, 2);
    chk(edge_mask_o == 0, "R8 suspend sets no bit", edge_mask_o, 0);
    chk(act_mode_o == 0, "R8 no pending from suspend", act_mode_o, 0);

    // lid opens with suspend low
    drive_sys(1, 1, 0); tick(3);
    chk(state_o == 1, "R3 host suspend", state_o, 1);
    chk(edge_mask_o == 4'b0010, "R6 lid rising edge", edge_mask_o, 2);
    tick(1); do_ack(); tick(1);

    // power fail
    drive_sys(0, 1, 0); tick(3);
    chk(state_o == 3, "R1 critical", state_o, 3);
    chk(edge_mask_o == 4'b0001, "R6 pg edge bit", edge_mask_o, 1);
    drive_sys(0, 0, 0); tick(3);
    chk(state_o == 3, "R1 critical over lid", state_o, 3);
    chk(edge_mask_o == 4'b0011, "R7 sticky accumulate", edge_mask_o, 3);
    drive_sys(1, 1, 1); tick(3);
    chk(state_o == 0, "R4 normal", state_o, 0);
    chk(edge_mask_o == 4'b0011, "R6 both rising", edge_mask_o, 3);
    do_ack(); tick(1);
    chk(act_mode_o == 0, "R9 stop idle", act_mode_o, 0);

    // timers and host transactions
    timer_en_i = 2'b10; tick(1);
    chk(act_mode_o == 1, "R10 wait on timer", act_mode_o, 1);
    host_busy_i = 1; tick(1);
    chk(act_mode_o == 2, "R11 run over wait", act_mode_o, 2);
    host_busy_i = 0; tick(1);
    chk(act_mode_o == 1, "R10 back to wait", act_mode_o, 1);
    timer_en_i = 0; tick(1);
    chk(act_mode_o == 0, "R9 back to stop", act_mode_o, 0);

    // switch held low
    sw_n_i[0] = 0; tick(3);
    chk(edge_mask_o == 4'b0100, "R6 switch fall", edge_mask_o, 4);
    tick(1);
    chk(act_mode_o == 2, "R11 run on event", act_mode_o, 2);
    do_ack(); tick(1);
    chk(act_mode_o == 2, "R11 run while held", act_mode_o, 2);
    sw_n_i[0] = 1; tick(3);
    chk(edge_mask_o == 4'b0100, "R6 switch rise", edge_mask_o, 4);
    do_ack(); tick(1);
    chk(act_mode_o == 0, "R9 stop after release", act_mode_o, 0);

    // single-cycle glitch on switch 1
    sw_n_i[1] = 0; tick(1); sw_n_i[1] = 1; tick(2);
    chk(edge_mask_o == 4'b1000, "R12 glitch edge", edge_mask_o, 8);
    do_ack(); tick(2);

    // edge coinciding with acknowledge
    drive_sys(1, 0, 1); tick(2);
    ack_i = 1; tick(1); ack_i = 0;
    chk(edge_mask_o == 4'b0010, "R7 edge kept on ack", edge_mask_o, 2);
    drive_sys(1, 1, 1); tick(3);
    do_ack(); tick(3);

    chk(exp_q.size() == 0, "R5 all alerts seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule